// File: doc/BRIEF.md
# Power-Down Sequencer with Wake Gating

This block sequences a small microcontroller system into and out of a low-power state. Firmware sets a power-down request bit. After a fixed grace period, in which the program halts its core, the block raises an analog shutdown output. That output turns off the oscillator, PLL, reference and bias circuits.

Any enabled external interrupt source ends the shutdown at once, without needing a clock. The sources are the user interrupt lines, the card interface interrupt and the keypad interrupt. When the clock is back, a settling counter runs on the processor clock. When it expires, a wake interrupt is raised.

A select bit decides what reaches the processor's interrupt 0 input: either the ordinary user interrupt or the settled wake interrupt. Firmware sets the select before it requests power-down. It acknowledges the wake interrupt to clear it.

Top module: `pwrdn_seq`

## Requirements
- R1: While reset is applied and after it is released, `pd_req`, `ana_off` and `int0` are all 0 until a stimulus arrives.
- R2: A one-cycle pulse on `pd_req_wr` sets `pd_req` at that clock edge. `ana_off` then rises at exactly the 32nd rising clock edge after that edge, and it stays high while no wake source is active.
- R3: While `pd_req` is 1, a high level on any bit of `usr_irq`, on `card_irq` or on `kpd_irq` drives `ana_off` to 0 immediately, with no clock edge needed.
- R4: After such a wake, `pd_req` reads 0 after the first clock edge. `ana_off` does not rise again.
- R5: A wake source that arrives during the 32-cycle grace period aborts the power-down, and `ana_off` never rises.
- R6: After a wake, the wake interrupt becomes active at exactly the 512th clock edge that occurs with the clock running and `ana_off` low.
- R7: With `wake_sel` = 0, `int0` equals the OR of the `usr_irq` bits. `card_irq`, `kpd_irq` and the wake interrupt have no effect on it.
- R8: With `wake_sel` = 1, `int0` carries only the wake interrupt. The `usr_irq` lines do not reach it.
- R9: A high `int0_ack` at a clock edge clears the wake interrupt, and `int0` reads 0 after that edge.
- R10: Wake sources that arrive while `pd_req` is 0 start no wake sequence, and `int0` stays 0 with `wake_sel` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock; stopped by the clock subsystem while `ana_off` is high |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously inside |
| pd_req_wr | input | 1 | Firmware write pulse that sets the power-down request bit |
| wake_sel | input | 1 | Interrupt 0 routing: 0 = user interrupt, 1 = settled wake interrupt |
| usr_irq | input | USR_W (8) | User interrupt lines; ORed into the user interrupt and into the wake OR |
| card_irq | input | 1 | Card interface interrupt (wake source) |
| kpd_irq | input | 1 | Keypad interrupt (wake source) |
| int0_ack | input | 1 | Firmware acknowledge of the wake interrupt |
| pd_req | output | 1 | Current value of the power-down request bit |
| ana_off | output | 1 | Analog shutdown: high powers down oscillator, PLL and bias |
| int0 | output | 1 | Processor interrupt 0 input |

## Verification
The assertions take for granted that the clock only stops while `ana_off` is high and restarts after the shutdown has dropped. They also assume that a wake source pulse has settled before the first restarted edge, and that `int0_ack` comes only after the wake interrupt is seen. The stimulus keeps to these limits. It gates the bench clock on `ana_off` and parks it low. It raises and drops the wake sources between clock edges, or while the clock is stopped. It pulses the acknowledge once, after `int0` has been checked high.

// File: rtl/pds_pkg.sv
package pds_pkg;
  localparam int unsigned GRACE_W_DEF  = 5;
  localparam int unsigned SETTLE_W_DEF = 9;
  localparam int unsigned USR_W_DEF    = 8;

  function automatic int unsigned cycles_of(input int unsigned w);
    return 32'd1 << w;
  endfunction
endpackage

// File: rtl/pds_rst_sync.sv
module pds_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pds_count.sv
// Saturating up-counter; terminal flag high once all bits are set.
module pds_count #(
  parameter int unsigned W = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic tc
);
  logic [W-1:0] cnt_q, cnt_d;

  assign tc = &cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)           cnt_d = '0;
    else if (en && !tc) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pds_wake_ctl.sv
// Request bit, wake latch and analog shutdown flop. The wake latch is set and
// the shutdown flop cleared asynchronously, since the clock is stopped.
module pds_wake_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic req_wr,
  input  logic wake_any,
  input  logic ack,
  input  logic grace_tc,
  output logic pd_req,
  output logic wake_lat,
  output logic ana_off
);
  logic req_q, req_d;
  logic lat_q, lat_d;
  logic off_q, off_d;
  logic wake_set;

  assign wake_set = wake_any & req_q;

  always_comb begin
    req_d = req_q;
    if (lat_q)       req_d = 1'b0;
    else if (req_wr) req_d = 1'b1;
  end

  always_comb begin
    lat_d = lat_q;
    if (ack) lat_d = 1'b0;
  end

  always_comb begin
    off_d = grace_tc & req_q & ~lat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  always_ff @(posedge clk or negedge rst_n or posedge wake_set) begin
    if (!rst_n)        lat_q <= 1'b0;
    else if (wake_set) lat_q <= 1'b1;
    else               lat_q <= lat_d;
  end

  always_ff @(posedge clk or negedge rst_n or posedge wake_set) begin
    if (!rst_n)        off_q <= 1'b0;
    else if (wake_set) off_q <= 1'b0;
    else               off_q <= off_d;
  end

  assign pd_req   = req_q;
  assign wake_lat = lat_q;
  assign ana_off  = off_q;
endmodule

// File: rtl/pds_int0_mux.sv
module pds_int0_mux #(
  parameter int unsigned USR_W = 8
) (
  input  logic             sel,
  input  logic [USR_W-1:0] usr_irq,
  input  logic             wake_irq,
  output logic             int0
);
  logic usr_int;

  assign usr_int = |usr_irq;

  always_comb begin
    int0 = sel ? wake_irq : usr_int;
  end
endmodule

// File: rtl/pwrdn_seq.sv
module pwrdn_seq
  import pds_pkg::*;
#(
  parameter int unsigned GRACE_W  = GRACE_W_DEF,
  parameter int unsigned SETTLE_W = SETTLE_W_DEF,
  parameter int unsigned USR_W    = USR_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pd_req_wr,
  input  logic             wake_sel,
  input  logic [USR_W-1:0] usr_irq,
  input  logic             card_irq,
  input  logic             kpd_irq,
  input  logic             int0_ack,
  output logic             pd_req,
  output logic             ana_off,
  output logic             int0
);
  logic rst_i_n;
  logic wake_any;
  logic wake_lat;
  logic grace_en, grace_clr, grace_tc;
  logic settle_en, settle_clr, settle_tc;
  logic wake_irq_q, wake_irq_d;

  pds_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  assign wake_any = (|usr_irq) | card_irq | kpd_irq;

  pds_wake_ctl u_ctl (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .req_wr   (pd_req_wr),
    .wake_any (wake_any),
    .ack      (int0_ack),
    .grace_tc (grace_tc),
    .pd_req   (pd_req),
    .wake_lat (wake_lat),
    .ana_off  (ana_off)
  );

  assign grace_en  = pd_req & ~wake_lat;
  assign grace_clr = ~grace_en;

  pds_count #(.W(GRACE_W)) u_grace (
    .clk   (clk),
    .rst_n (rst_i_n),
    .clr   (grace_clr),
    .en    (grace_en),
    .tc    (grace_tc)
  );

  assign settle_en  = wake_lat & ~ana_off;
  assign settle_clr = ~wake_lat;

  pds_count #(.W(SETTLE_W)) u_settle (
    .clk   (clk),
    .rst_n (rst_i_n),
    .clr   (settle_clr),
    .en    (settle_en),
    .tc    (settle_tc)
  );

  always_comb begin
    wake_irq_d = wake_lat & ~int0_ack & settle_tc;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) wake_irq_q <= 1'b0;
    else          wake_irq_q <= wake_irq_d;
  end

  pds_int0_mux #(.USR_W(USR_W)) u_mux (
    .sel      (wake_sel),
    .usr_irq  (usr_irq),
    .wake_irq (wake_irq_q),
    .int0     (int0)
  );
endmodule

// File: rtl/pds_chk.sv
module pds_chk #(
  parameter int unsigned GRACE_W  = 5,
  parameter int unsigned SETTLE_W = 9,
  parameter int unsigned USR_W    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pd_req,
  input logic             ana_off,
  input logic             wake_lat,
  input logic             wake_irq,
  input logic             wake_any,
  input logic             wake_sel,
  input logic [USR_W-1:0] usr_irq,
  input logic             int0_ack,
  input logic             int0
);
  localparam int unsigned GRACE_N  = 1 << GRACE_W;
  localparam int unsigned SETTLE_N = 1 << SETTLE_W;

  logic [GRACE_W:0]  req_run;
  logic [SETTLE_W:0] settle_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     req_run <= '0;
    else if (!pd_req)               req_run <= '0;
    else if (req_run != GRACE_N[GRACE_W:0]) req_run <= req_run + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               settle_run <= '0;
    else if (!wake_lat)                       settle_run <= '0;
    else if (!ana_off && settle_run != SETTLE_N[SETTLE_W:0]) settle_run <= settle_run + 1'b1;
  end

  // R2: shutdown never ahead of the grace window
  p_no_early_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_run < GRACE_N[GRACE_W:0]) |-> !ana_off);

  // R4: shutdown only with a pending request
  p_off_has_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ana_off |-> pd_req);

  // R4: a latched wake clears the request bit
  p_wake_clears_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wake_lat |=> !pd_req);

  // R6: wake interrupt only after the full settle count
  p_settle_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_irq) |-> (settle_run == SETTLE_N[SETTLE_W:0]));

  // R7: select 0 routes the user lines
  p_user_route_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wake_sel |-> (int0 == (|usr_irq)));

  // R9: acknowledge clears the wake interrupt
  p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (int0_ack && !(wake_any && pd_req)) |=> !wake_irq);
endmodule

bind pwrdn_seq pds_chk #(
  .GRACE_W  (GRACE_W),
  .SETTLE_W (SETTLE_W),
  .USR_W    (USR_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pd_req   (pd_req),
  .ana_off  (ana_off),
  .wake_lat (wake_lat),
  .wake_irq (wake_irq_q),
  .wake_any (wake_any),
  .wake_sel (wake_sel),
  .usr_irq  (usr_irq),
  .int0_ack (int0_ack),
  .int0     (int0)
);

// File: tb/sim_pwrdn_seq.sv
`timescale 1ns/1ps
module sim_pwrdn_seq;
  logic       clk;
  logic       rst_n;
  logic       pd_req_wr;
  logic       wake_sel;
  logic [7:0] usr_irq;
  logic       card_irq;
  logic       kpd_irq;
  logic       int0_ack;
  logic       pd_req;
  logic       ana_off;
  logic       int0;

  int n_chk;
  int n_bad;

  pwrdn_seq u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .pd_req_wr (pd_req_wr),
    .wake_sel  (wake_sel),
    .usr_irq   (usr_irq),
    .card_irq  (card_irq),
    .kpd_irq   (kpd_irq),
    .int0_ack  (int0_ack),
    .pd_req    (pd_req),
    .ana_off   (ana_off),
    .int0      (int0)
  );

  // 50 MHz; parks low while the analog shutdown is high
  initial clk = 1'b0;
  always begin
    #10;
    if (!ana_off || clk) clk = ~clk;
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic request_pd();
    @(negedge clk);
    pd_req_wr = 1'b1;
    @(posedge clk);
    #1;
    pd_req_wr = 1'b0;
  endtask

  // counts edges after a wake until int0 rises; flags any shutdown re-entry
  task automatic settle_count(output int n, output bit reoff);
    bit got;
    n = 0; got = 1'b0; reoff = 1'b0;
    while (!got && n < 600) begin
      @(posedge clk);
      #1;
      n++;
      if (ana_off) reoff = 1'b1;
      got = int0;
    end
  endtask

  task automatic ack_wake(input string rq);
    @(negedge clk);
    int0_ack = 1'b1;
    @(posedge clk);
    #1;
    int0_ack = 1'b0;
    chk(int0 == 1'b0, rq, "int0 after ack", int0, 0);
  endtask

  task automatic t_reset();
    chk(pd_req == 1'b0 && ana_off == 1'b0 && int0 == 1'b0, "R1",
        "outputs after reset", {pd_req, ana_off, int0}, 0);
  endtask

  task automatic t_mux_user();
    @(negedge clk);
    wake_sel = 1'b0;
    usr_irq = 8'h80;
    #1;
    chk(int0 == 1'b1, "R7", "user line routed", int0, 1);
    usr_irq = 8'h00;
    card_irq = 1'b1;
    #1;
    chk(int0 == 1'b0, "R7", "card not routed with sel 0", int0, 0);
    card_irq = 1'b0;
  endtask

  task automatic t_ignore_idle();
    bit seen;
    seen = 1'b0;
    @(negedge clk);
    wake_sel = 1'b1;
    card_irq = 1'b1;
    kpd_irq = 1'b1;
    #3;
    card_irq = 1'b0;
    kpd_irq = 1'b0;
    for (int i = 0; i < 600; i++) begin
      @(posedge clk);
      #1;
      if (int0 || ana_off) seen = 1'b1;
    end
    chk(!seen, "R10", "no wake sequence without request", seen, 0);
  endtask

  task automatic t_full_cycle();
    bit early;
    bit reoff;
    int n;
    early = 1'b0;
    @(negedge clk);
    wake_sel = 1'b1;
    request_pd();
    chk(pd_req == 1'b1, "R2", "request bit set", pd_req, 1);
    for (int i = 1; i <= 32; i++) begin
      @(posedge clk);
      #1;
      if (i < 32 && ana_off) early = 1'b1;
    end
    chk(!early, "R2", "shutdown before edge 32", early, 0);
    chk(ana_off == 1'b1, "R2", "shutdown at edge 32", ana_off, 1);
    #200;
    chk(ana_off == 1'b1 && clk == 1'b0, "R2", "shutdown held, clock parked",
        {ana_off, clk}, 2);
    kpd_irq = 1'b1;
    #2;
    chk(ana_off == 1'b0, "R3", "keypad ends shutdown without clock", ana_off, 0);
    #5;
    kpd_irq = 1'b0;
    @(posedge clk);
    #1;
    chk(pd_req == 1'b0, "R4", "request cleared on first edge", pd_req, 0);
    usr_irq = 8'h04;
    #1;
    chk(int0 == 1'b0, "R8", "user line blocked with sel 1", int0, 0);
    usr_irq = 8'h00;
    settle_count(n, reoff);
    chk(n + 1 == 512, "R6", "settle edges", n + 1, 512);
    chk(!reoff, "R4", "shutdown re-entered", reoff, 0);
    chk(int0 == 1'b1, "R8", "wake interrupt on int0", int0, 1);
    ack_wake("R9");
  endtask

  task automatic t_abort();
    bit reoff;
    int n;
    @(negedge clk);
    wake_sel = 1'b1;
    request_pd();
    repeat (10) @(posedge clk);
    @(negedge clk);
    card_irq = 1'b1;
    #3;
    card_irq = 1'b0;
    settle_count(n, reoff);
    chk(!reoff, "R5", "shutdown during aborted grace", reoff, 0);
    chk(pd_req == 1'b0, "R4", "request cleared after abort", pd_req, 0);
    chk(n == 512, "R6", "settle edges after abort", n, 512);
    ack_wake("R9");
  endtask

  task automatic t_user_wake_sel0();
    bit hit;
    hit = 1'b0;
    @(negedge clk);
    wake_sel = 1'b0;
    request_pd();
    repeat (32) @(posedge clk);
    #100;
    chk(ana_off == 1'b1, "R2", "shutdown with sel 0", ana_off, 1);
    usr_irq = 8'h10;
    #2;
    chk(ana_off == 1'b0, "R3", "user line ends shutdown", ana_off, 0);
    chk(int0 == 1'b1, "R7", "user line direct on int0", int0, 1);
    #5;
    usr_irq = 8'h00;
    for (int i = 0; i < 600; i++) begin
      @(posedge clk);
      #1;
      if (int0) hit = 1'b1;
    end
    chk(!hit, "R7", "wake interrupt hidden with sel 0", hit, 0);
    @(negedge clk);
    wake_sel = 1'b1;
    #1;
    chk(int0 == 1'b1, "R8", "pending wake visible on sel 1", int0, 1);
    ack_wake("R9");
  endtask

  initial begin
    #4_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog (all requirements): actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; pd_req_wr = 1'b0; wake_sel = 1'b0; usr_irq = 8'h00;
    card_irq = 1'b0; kpd_irq = 1'b0; int0_ack = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk(pd_req == 1'b0 && ana_off == 1'b0 && int0 == 1'b0, "R1",
        "outputs during reset", {pd_req, ana_off, int0}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    t_reset();
    t_mux_user();
    t_ignore_idle();
    t_full_cycle();
    t_abort();
    t_user_wake_sel0();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule